// File: doc/BRIEF.md
# Ordered Request Retry Queue

This block sits between a translation engine and two downstream request ports. The main port carries every transaction that leaves for memory. An optional walk port carries only intermediate table-walk fetches. Each upstream request carries a final/walk-fetch tag and a data word. The block tries to hand each request straight to its port in the same cycle. If the port refuses it, or if older requests for that port are still waiting, the request is appended to that port's retry queue, so per-port order is never broken. When a port later pulses its retry input, the queue is drained from the head, one entry per cycle, until the port refuses again or the queue runs dry.

Every port has its own two-state controller. In `PC_IDLE` it may issue directly, and only when its queue is empty. `PC_IDLE -> PC_DRAIN` is taken when a retry arrives while the queue holds entries. In `PC_DRAIN` the head is presented on the port. `PC_DRAIN -> PC_IDLE` is taken on the first refusal, or when the accepted entry was the last one. Whether walk fetches use the walk port is latched while reset is held, from a strap that says whether that port is connected.

Certain sends tell the upstream interfaces that they may try again, by a pulse on every bit of `up_retry`. These are a directly issued request on either port, and a final transaction drained from the main queue.

Top module: `req_retry_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `mp_valid` and `wp_valid` are 0 and `up_retry` is all zero.
- R2: A request accepted while its target queue is empty and its controller is in `PC_IDLE` appears on that port in the same cycle. It carries the same `in_data`, and on the main port `mp_final` equals `in_final`. If the port accepts it, nothing is queued.
- R3: A request is queued instead of issued when its port refuses it or when its queue already holds entries, even if the port would accept. Each port delivers its requests in arrival order.
- R4: A pulse on a port's retry input while its queue is non-empty starts draining in the next cycle. The head entry is presented and removed on each cycle the port accepts, one entry per cycle.
- R5: Draining stops at the first refusal. The refused entry stays at the head, the port valid drops in the next cycle, and the entry is the next one sent after a later retry.
- R6: `in_final` = 1 marks a final transaction and 0 a walk fetch. Walk fetches go to the walk port when `walk_port_present` was 1 during reset. Otherwise they go to the main port with `mp_final` = 0, and `wp_valid` stays 0.
- R7: `walk_port_present` is sampled only while `rst_n` is low. Changing it after reset has no effect on steering.
- R8: All bits of `up_retry` are 1 in the cycle after a request is issued directly on either port, or after a final entry is drained from the main queue. A walk fetch drained from a queue raises no pulse. Otherwise `up_retry` is 0.
- R9: `in_ready` is 0 while either queue holds its full depth of entries. No entry is ever written into a full queue.
- R10: A retry pulse that arrives while the queue is empty has no effect: the port valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asynchronous for state, steering strap captured while low |
| walk_port_present | input | 1 | Strap: walk port is connected |
| in_valid | input | 1 | Upstream request valid |
| in_final | input | 1 | 1 = final transaction, 0 = walk fetch |
| in_data | input | DATA_W | Request payload/address word |
| in_ready | output | 1 | Request can be taken this cycle |
| mp_valid | output | 1 | Main port request valid |
| mp_final | output | 1 | Main port request is a final transaction |
| mp_data | output | DATA_W | Main port request word |
| mp_accept | input | 1 | Main port takes the request this cycle |
| mp_retry | input | 1 | Main port retry pulse |
| wp_valid | output | 1 | Walk port request valid |
| wp_data | output | DATA_W | Walk port request word |
| wp_accept | input | 1 | Walk port takes the request this cycle |
| wp_retry | input | 1 | Walk port retry pulse |
| up_retry | output | N_IFC | Per-interface retry notification pulse |

## Verification
The bench drives four input patterns. Single requests to a willing port separate the direct path from the queued path. Bursts against a refusing port, followed by a retry, show per-port ordering and one-per-cycle draining. A drain cut short by a refusal in its second cycle shows that the head survives and that draining resumes on the next retry. The same mixed walk/final stream is run with the walk port strapped present and then absent, which tells the steering apart and shows which sends raise the upstream notification. Filling the queue to depth, and retrying into an empty queue, cover the boundaries.

// File: rtl/rrq_pkg.sv
package rrq_pkg;
    typedef enum logic {
        PC_IDLE  = 1'b0,
        PC_DRAIN = 1'b1
    } pc_state_e;
endpackage

// File: rtl/rrq_fifo.sv
module rrq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [W-1:0]                  push_data,
    input  logic                          pop,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          empty,
    output logic                          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt;
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    // R9: nothing is written into a full queue
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full))
        else $error("queue overflow");

    // R4: only existing entries are removed
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty)
        else $error("queue underflow");
endmodule

// File: rtl/rrq_port_ctrl.sv
module rrq_port_ctrl
    import rrq_pkg::*;
#(
    parameter int W     = 17,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         new_valid,
    input  logic [W-1:0] new_entry,
    input  logic         port_accept,
    input  logic         port_retry,
    output logic         port_valid,
    output logic [W-1:0] port_entry,
    output logic         q_full,
    output logic         direct_sent,
    output logic         drained_sent
);
    localparam int CW = $clog2(DEPTH + 1);

    pc_state_e     state_q, state_d;
    logic          push, pop, q_empty;
    logic [W-1:0]  q_head;
    logic [CW-1:0] q_count;

    rrq_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (new_entry),
        .pop       (pop),
        .head      (q_head),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PC_IDLE: begin
                if (port_retry && !q_empty) state_d = PC_DRAIN;
            end
            PC_DRAIN: begin
                if (!port_accept)                          state_d = PC_IDLE;
                else if (q_count == CW'(1) && !push)        state_d = PC_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        port_valid  = 1'b0;
        port_entry  = new_entry;
        pop         = 1'b0;
        direct_sent = 1'b0;
        unique case (state_q)
            PC_IDLE: begin
                port_valid  = new_valid && q_empty;
                port_entry  = new_entry;
                direct_sent = new_valid && q_empty && port_accept;
            end
            PC_DRAIN: begin
                port_valid = 1'b1;
                port_entry = q_head;
                pop        = port_accept;
            end
        endcase
        push         = new_valid && !direct_sent;
        drained_sent = pop;
    end

    // R5: a refused head stays at the head and draining pauses
    assert_refusal_keeps_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PC_DRAIN && !port_accept) |=> (state_q == PC_IDLE && $stable(q_head)))
        else $error("refused head lost");

    // R4: the queue only shrinks on an accepted port cycle
    assert_shrink_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count < $past(q_count)) |-> $past(port_valid && port_accept))
        else $error("entry removed without acceptance");

    // R3: the port never shows a new request while older entries wait
    assert_queue_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_valid && q_count != '0) |-> (port_entry == q_head))
        else $error("queued entries bypassed");
endmodule

// File: rtl/rrq_notify.sv
module rrq_notify #(
    parameter int N_IFC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output logic [N_IFC-1:0] up_retry
);
    for (genvar i = 0; i < N_IFC; i++) begin : g_ifc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) up_retry[i] <= 1'b0;
            else        up_retry[i] <= fire;
        end
    end
endmodule

// File: rtl/req_retry_queue.sv
module req_retry_queue #(
    parameter int DATA_W     = 16,
    parameter int MAIN_DEPTH = 4,
    parameter int WALK_DEPTH = 4,
    parameter int N_IFC      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_port_present,
    input  logic              in_valid,
    input  logic              in_final,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              mp_valid,
    output logic              mp_final,
    output logic [DATA_W-1:0] mp_data,
    input  logic              mp_accept,
    input  logic              mp_retry,
    output logic              wp_valid,
    output logic [DATA_W-1:0] wp_data,
    input  logic              wp_accept,
    input  logic              wp_retry,
    output logic [N_IFC-1:0]  up_retry
);
    localparam int MAIN_W = DATA_W + 1;

    logic              walk_en_q;
    logic              take, to_walk;
    logic              main_full, walk_full;
    logic              main_direct, main_drained, walk_direct, walk_drained;
    logic [MAIN_W-1:0] main_entry;
    logic              fire;

    // steering strap is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) walk_en_q <= walk_port_present;
    end

    assign in_ready = !main_full && !walk_full;
    assign take     = in_valid && in_ready;
    assign to_walk  = walk_en_q && !in_final;

    rrq_port_ctrl #(.W(MAIN_W), .DEPTH(MAIN_DEPTH)) main_ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .new_valid    (take && !to_walk),
        .new_entry    ({in_final, in_data}),
        .port_accept  (mp_accept),
        .port_retry   (mp_retry),
        .port_valid   (mp_valid),
        .port_entry   (main_entry),
        .q_full       (main_full),
        .direct_sent  (main_direct),
        .drained_sent (main_drained)
    );

    assign mp_final = main_entry[DATA_W];
    assign mp_data  = main_entry[DATA_W-1:0];

    rrq_port_ctrl #(.W(DATA_W), .DEPTH(WALK_DEPTH)) walk_ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .new_valid    (take && to_walk),
        .new_entry    (in_data),
        .port_accept  (wp_accept),
        .port_retry   (wp_retry),
        .port_valid   (wp_valid),
        .port_entry   (wp_data),
        .q_full       (walk_full),
        .direct_sent  (walk_direct),
        .drained_sent (walk_drained)
    );

    assign fire = main_direct || walk_direct || (main_drained && mp_final);

    rrq_notify #(.N_IFC(N_IFC)) notify_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .up_retry (up_retry)
    );

    // R6: walk port idle when it was not strapped present
    assert_walk_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_en_q |-> !wp_valid)
        else $error("walk port used while absent");

    // R7: steering does not change after reset
    assert_walk_sel_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(walk_en_q))
        else $error("steering changed after reset");

    // R8: a notification follows an accepted send
    assert_retry_after_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_retry[0] |-> $past((mp_valid && mp_accept) || (wp_valid && wp_accept)))
        else $error("notification without send");

    // R8: every interface sees the same pulse
    assert_ifc_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_retry == '0) || (&up_retry))
        else $error("interfaces disagree");

    // R8: a drained walk fetch alone raises nothing
    assert_walk_drain_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_drained && !main_direct && !main_drained) |=> (up_retry == '0))
        else $error("drained walk fetch notified");
endmodule

// File: tb/req_retry_queue_tb_top.sv
module req_retry_queue_tb_top;
    localparam int DW = 16;
    localparam int MD = 4;
    localparam int WD = 4;
    localparam int NI = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          walk_port_present = 1'b1;
    logic          in_valid = 1'b0, in_final = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          mp_valid, mp_final;
    logic [DW-1:0] mp_data;
    logic          mp_accept = 1'b0, mp_retry = 1'b0;
    logic          wp_valid;
    logic [DW-1:0] wp_data;
    logic          wp_accept = 1'b0, wp_retry = 1'b0;
    logic [NI-1:0] up_retry;

    int checks = 0;
    int failures = 0;
    logic [DW:0]   exp_main[$];
    logic [DW-1:0] exp_walk[$];
    logic          exp_walk_en = 1'b1;
    logic [DW-1:0] tag = 16'h0100;
    logic          prev_fire = 1'b0;
    bit            finished = 0;

    always #10 clk = ~clk;

    req_retry_queue #(.DATA_W(DW), .MAIN_DEPTH(MD), .WALK_DEPTH(WD), .N_IFC(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .walk_port_present(walk_port_present),
        .in_valid(in_valid), .in_final(in_final), .in_data(in_data), .in_ready(in_ready),
        .mp_valid(mp_valid), .mp_final(mp_final), .mp_data(mp_data),
        .mp_accept(mp_accept), .mp_retry(mp_retry),
        .wp_valid(wp_valid), .wp_data(wp_data), .wp_accept(wp_accept), .wp_retry(wp_retry),
        .up_retry(up_retry)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // driver: called at a negedge, returns at a later negedge
    task automatic send(input logic f);
        in_valid = 1'b1;
        in_final = f;
        in_data  = tag;
        if (exp_walk_en && !f) exp_walk.push_back(tag);
        else                   exp_main.push_back({f, tag});
        tag = tag + 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic main_retry();
        mp_retry = 1'b1;
        @(negedge clk);
        mp_retry = 1'b0;
    endtask

    task automatic walk_retry();
        wp_retry = 1'b1;
        @(negedge clk);
        wp_retry = 1'b0;
    endtask

    task automatic do_reset(input logic present);
        rst_n = 1'b0;
        walk_port_present = present;
        in_valid = 1'b0; mp_retry = 1'b0; wp_retry = 1'b0;
        mp_accept = 1'b0; wp_accept = 1'b0;
        repeat (4) @(negedge clk);
        exp_main.delete();
        exp_walk.delete();
        exp_walk_en = present;
        rst_n = 1'b1;
    endtask

    // monitor: scoreboard of port traffic and upstream notification
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                prev_fire = 1'b0;
            end else begin
                logic fire;
                logic direct;
                fire = 1'b0;
                chk(up_retry == {NI{prev_fire}}, "R8", "up_retry", up_retry, {NI{prev_fire}});
                if (mp_valid && mp_accept) begin
                    direct = in_valid && in_ready && ({in_final, in_data} == {mp_final, mp_data});
                    if (exp_main.size() == 0) begin
                        chk(1'b0, "R3", "unexpected main send", {mp_final, mp_data}, 0);
                    end else begin
                        logic [DW:0] e;
                        e = exp_main.pop_front();
                        chk({mp_final, mp_data} == e, "R3", "main order/content",
                            {mp_final, mp_data}, e);
                    end
                    if (mp_final || direct) fire = 1'b1;
                end
                if (wp_valid && wp_accept) begin
                    direct = in_valid && in_ready && !in_final && (in_data == wp_data);
                    if (exp_walk.size() == 0) begin
                        chk(1'b0, "R6", "unexpected walk send", wp_data, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_walk.pop_front();
                        chk(wp_data == e, "R6", "walk order/content", wp_data, e);
                    end
                    if (direct) fire = 1'b1;
                end
                prev_fire = fire;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        #3;
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(mp_valid == 1'b0, "R1", "mp_valid after reset", mp_valid, 0);
        chk(wp_valid == 1'b0, "R1", "wp_valid after reset", wp_valid, 0);
        chk(up_retry == '0,   "R1", "up_retry after reset", up_retry, 0);
        @(negedge clk);

        // R2: direct issue to a willing main port
        mp_accept = 1'b1;
        in_valid = 1'b1; in_final = 1'b1; in_data = tag;
        exp_main.push_back({1'b1, tag}); tag = tag + 1'b1;
        #3;
        chk(mp_valid == 1'b1, "R2", "direct same-cycle valid", mp_valid, 1);
        chk(mp_data == in_data, "R2", "direct data", mp_data, in_data);
        @(negedge clk);
        in_valid = 1'b0;
        #3;
        chk(exp_main.size() == 0, "R2", "direct consumed", exp_main.size(), 0);
        @(negedge clk);

        // R3: refusal queues; waiting entries block a willing port
        mp_accept = 1'b0;
        send(1'b1);
        send(1'b1);
        mp_accept = 1'b1;
        in_valid = 1'b1; in_final = 1'b1; in_data = tag;
        exp_main.push_back({1'b1, tag}); tag = tag + 1'b1;
        #3;
        chk(mp_valid == 1'b0, "R3", "no bypass of queued entries", mp_valid, 0);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        #3;
        chk(exp_main.size() == 3, "R3", "held until retry", exp_main.size(), 3);
        @(negedge clk);

        // R4: retry drains one per cycle
        main_retry();
        #3;
        chk(mp_valid == 1'b1, "R4", "drain starts after retry", mp_valid, 1);
        @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        chk(exp_main.size() == 0, "R4", "drain complete", exp_main.size(), 0);
        chk(mp_valid == 1'b0, "R4", "idle after drain", mp_valid, 0);
        @(negedge clk);

        // R5: drain stops at first refusal, head kept
        mp_accept = 1'b0;
        send(1'b1); send(1'b1); send(1'b1);
        mp_accept = 1'b1;
        main_retry();
        @(negedge clk);           // first entry accepted here
        mp_accept = 1'b0;
        @(negedge clk);           // second refused
        #3;
        chk(mp_valid == 1'b0, "R5", "valid drops after refusal", mp_valid, 0);
        chk(exp_main.size() == 2, "R5", "entries left", exp_main.size(), 2);
        @(negedge clk);
        repeat (2) @(negedge clk);
        mp_accept = 1'b1;
        main_retry();
        repeat (4) @(negedge clk);
        #3;
        chk(exp_main.size() == 0, "R5", "resumed from kept head", exp_main.size(), 0);
        @(negedge clk);

        // R10: retry into an empty queue
        main_retry();
        #3;
        chk(mp_valid == 1'b0, "R10", "empty retry ignored", mp_valid, 0);
        @(negedge clk);

        // R6: walk fetches to walk port; drained walk fetch raises no pulse
        wp_accept = 1'b1;
        send(1'b0);
        #3;
        chk(exp_walk.size() == 0, "R6", "walk direct consumed", exp_walk.size(), 0);
        @(negedge clk);
        wp_accept = 1'b0;
        send(1'b0); send(1'b0);
        send(1'b1);               // main still accepts: independent path
        wp_accept = 1'b1;
        walk_retry();
        repeat (4) @(negedge clk);
        #3;
        chk(exp_walk.size() == 0, "R6", "walk drain done", exp_walk.size(), 0);
        @(negedge clk);

        // R9: full main queue blocks upstream
        mp_accept = 1'b0;
        for (int i = 0; i < MD; i++) send(1'b1);
        #3;
        chk(in_ready == 1'b0, "R9", "ready low when full", in_ready, 0);
        @(negedge clk);
        mp_accept = 1'b1;
        main_retry();
        repeat (MD + 2) @(negedge clk);
        #3;
        chk(in_ready == 1'b1, "R9", "ready back after drain", in_ready, 1);
        chk(exp_main.size() == 0, "R9", "full queue drained", exp_main.size(), 0);
        @(negedge clk);

        // R6/R7: walk port absent; strap change after reset ignored
        do_reset(1'b0);
        @(negedge clk);
        walk_port_present = 1'b1;
        mp_accept = 1'b0;
        send(1'b0);
        send(1'b1);
        #3;
        chk(wp_valid == 1'b0, "R7", "walk port unused", wp_valid, 0);
        chk(exp_main.size() == 2, "R6", "walk fetch on main queue", exp_main.size(), 2);
        @(negedge clk);
        mp_accept = 1'b1;
        main_retry();
        repeat (3) @(negedge clk);
        send(1'b0);               // direct walk fetch on main: notifies
        repeat (2) @(negedge clk);
        #3;
        chk(exp_main.size() == 0, "R7", "main carried all", exp_main.size(), 0);
        chk(exp_walk.size() == 0, "R6", "nothing for walk", exp_walk.size(), 0);
        @(negedge clk);

        finished = 1;
        summary();
        $finish;
    end
endmodule